// File: doc/BRIEF.md
# Streaming Bytecode Instruction Verifier

This block screens a program for a register-based bytecode machine before it is allowed to run. The program arrives one fixed 64-bit instruction slot at a time over a valid/ready handshake. A start marker flags the first slot and a last marker flags the final slot. A version number comes with the first slot and selects which opcode rules apply to the whole program.

For each slot the block decodes the opcode, the source register and the immediate. It then decides whether the slot is an unknown opcode or an indirect call with a bad register operand. The first fault of a program is kept, as an error code and the zero-based slot index. The block also counts instructions. One cycle after the last slot is accepted, it presents a one-cycle result carrying a pass/fail flag and the instruction count.

Programs of version 2 and above use the single-slot rules. Older programs are checked against the legacy opcode table, in which the wide-immediate load takes two slots.

Top module: `bytecode_verifier`

## Requirements
- R1: Synchronous active-high reset drives doneValid low, errCode to 0, errIndex and doneCount to 0, and inReady high.
- R2: A slot is consumed on every cycle in which inValid and inReady are both high. inReady is low only while doneValid is high.
- R3: Slot layout: opcode in bits 7:0, source register in bits 15:12, immediate in bits 63:32. With version >= 2, opcodes 0x00, 0x18 and 0xD4 are faults of errCode 1 (unknown opcode).
- R4: With version >= 2, opcodes 0x61, 0x62, 0x63, 0x69, 0x6A, 0x6B, 0x71, 0x72, 0x73, 0x79, 0x7A and 0x7B are faults of errCode 1.
- R5: With version >= 2, opcode 0xF7 and opcodes 0x27, 0x2C, 0x2F, 0x37, 0x3C, 0x3F, 0x87, 0x8C, 0x8F, 0x97, 0x9C and 0x9F are accepted, as is every opcode not listed in R3 and R4.
- R6: With version >= 2, an indirect call (opcode 0x8D) whose source register is above 9 is a fault of errCode 2 (bad call register). Its immediate has no effect.
- R7: With version < 2, opcode 0xF7 and the R5 relocated opcodes are faults of errCode 1, and all other opcodes are accepted. An indirect call there faults with errCode 2 when its immediate, read as unsigned, is above 9.
- R8: With version >= 2, the instruction count equals the number of slots. With version < 2, the slot that follows an opcode 0x18 slot is its second half: it is neither counted nor decoded.
- R9: The first fault of a program latches errCode and errIndex (its zero-based slot index). Later faults do not change them. A start-marked slot clears them.
- R10: One cycle after the last-marked slot is accepted, doneValid is high for exactly one cycle. In that cycle donePass is high exactly when errCode is 0, and doneCount holds the program's instruction count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Slot offered |
| inReady | output | 1 | Slot can be accepted |
| inSlot | input | 64 | Instruction slot |
| inFirst | input | 1 | Slot is the first of a program |
| inLast | input | 1 | Slot is the last of a program |
| progVersion | input | 8 | Program version, sampled with the first slot |
| doneValid | output | 1 | One-cycle result strobe |
| donePass | output | 1 | Program had no fault |
| doneCount | output | 32 | Instruction count of the program |
| errCode | output | 2 | 0 none, 1 unknown opcode, 2 bad call register |
| errIndex | output | 32 | Slot index of the first fault |

## Verification
The checker enforces several rules on every cycle:
- the result strobe lasts one cycle and always follows the acceptance of a last-marked slot;
- inReady is low during the result;
- the pass flag agrees with the error code;
- a latched fault stays put until a new program starts;
- reset clears the result state.

Other behaviour can only be shown by the bench's programs, which run against a behavioural model:
- which opcodes are legal under each version;
- that the call check reads the source register under the new rules and the immediate under the old ones;
- how the legacy second half drops out of the count;
- which slot index is reported.

// File: rtl/bytecode_verifier_pkg.sv
package bytecode_verifier_pkg;
  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_UNKNOWN   = 2'd1,
    ERR_CALL_REG  = 2'd2
  } errKind_e;

  typedef struct packed {
    logic accept;   // slot consumed this cycle
    logic restart;  // consumed slot starts a program
    logic finish;   // consumed slot ends a program
  } ctrlStrobes_t;

  localparam logic [7:0] OP_WIDE_LOAD = 8'h18;
  localparam logic [7:0] OP_WIDE_HALF = 8'h00;
  localparam logic [7:0] OP_LE_CONV   = 8'hD4;
  localparam logic [7:0] OP_HIGH_OR   = 8'hF7;
  localparam logic [7:0] OP_CALL_IND  = 8'h8D;
endpackage

// File: rtl/slot_classifier.sv
module slot_classifier
  import bytecode_verifier_pkg::*;
#(
  parameter int SLOT_W       = 64,
  parameter int MAX_CALL_REG = 9
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              legacyRules,
  output logic              unknownOp,
  output logic              badCallReg,
  output logic              isWideLoad
);
  localparam int IMM_LSB = SLOT_W - 32;

  logic [7:0]  opcode;
  logic [3:0]  srcReg;
  logic [31:0] immVal;
  logic [3:0]  opHi;
  logic [3:0]  opLo;
  logic        oldMemOp;
  logic        newMemOp;
  logic        newOnlyOp;
  logic        droppedOp;

  assign opcode = slot[7:0];
  assign srcReg = slot[15:12];
  assign immVal = slot[IMM_LSB +: 32];
  assign opHi   = opcode[7:4];
  assign opLo   = opcode[3:0];

  // legacy memory group: rows 6 and 7, columns 1..3 and 9..B
  always_comb begin
    oldMemOp = 1'b0;
    if (opHi == 4'h6 || opHi == 4'h7) begin
      case (opLo)
        4'h1, 4'h2, 4'h3, 4'h9, 4'hA, 4'hB: oldMemOp = 1'b1;
        default: oldMemOp = 1'b0;
      endcase
    end
  end

  // relocated memory group: rows 2, 3, 8, 9, columns 7, C, F
  always_comb begin
    newMemOp = 1'b0;
    case (opHi)
      4'h2, 4'h3, 4'h8, 4'h9: begin
        case (opLo)
          4'h7, 4'hC, 4'hF: newMemOp = 1'b1;
          default: newMemOp = 1'b0;
        endcase
      end
      default: newMemOp = 1'b0;
    endcase
  end

  assign newOnlyOp = newMemOp || (opcode == OP_HIGH_OR);
  assign droppedOp = oldMemOp || (opcode == OP_WIDE_LOAD) ||
                     (opcode == OP_WIDE_HALF) || (opcode == OP_LE_CONV);

  always_comb begin
    unknownOp  = legacyRules ? newOnlyOp : droppedOp;
    badCallReg = 1'b0;
    if (opcode == OP_CALL_IND) begin
      if (legacyRules) badCallReg = (immVal > 32'(MAX_CALL_REG));
      else             badCallReg = (srcReg > 4'(MAX_CALL_REG));
    end
    isWideLoad = legacyRules && (opcode == OP_WIDE_LOAD);
  end
endmodule

// File: rtl/verifier_control.sv
module verifier_control
  import bytecode_verifier_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inFirst,
  input  logic         inLast,
  output logic         inReady,
  output logic         doneValid,
  output ctrlStrobes_t strobes
);
  logic doneReg;

  assign inReady         = !doneReg;
  assign strobes.accept  = inValid && !doneReg;
  assign strobes.restart = inValid && !doneReg && inFirst;
  assign strobes.finish  = inValid && !doneReg && inLast;

  always_ff @(posedge clk) begin
    if (rst) doneReg <= 1'b0;
    else     doneReg <= strobes.finish;
  end

  assign doneValid = doneReg;
endmodule

// File: rtl/verifier_datapath.sv
module verifier_datapath
  import bytecode_verifier_pkg::*;
#(
  parameter int SLOT_W       = 64,
  parameter int CNT_W        = 32,
  parameter int VER_W        = 8,
  parameter int MIN_NEW_VER  = 2,
  parameter int MAX_CALL_REG = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic [VER_W-1:0]  progVersion,
  output logic [CNT_W-1:0]  instrCount,
  output logic [1:0]        errCode,
  output logic [CNT_W-1:0]  errIndex
);
  logic             legacyReg;
  logic             skipNext;
  logic [CNT_W-1:0] slotIdx;
  logic [CNT_W-1:0] countReg;
  errKind_e         errReg;
  logic [CNT_W-1:0] errIdxReg;

  logic             legacyEff;
  logic             skipEff;
  logic [CNT_W-1:0] idxEff;
  logic [CNT_W-1:0] countBase;
  logic             unknownOp;
  logic             badCallReg;
  logic             isWideLoad;
  logic             slotFault;
  logic             takeFault;
  errKind_e         faultKind;

  assign legacyEff = strobes.restart ? (progVersion < VER_W'(MIN_NEW_VER)) : legacyReg;
  assign skipEff   = !strobes.restart && skipNext;
  assign idxEff    = strobes.restart ? '0 : slotIdx;
  assign countBase = strobes.restart ? '0 : countReg;

  slot_classifier #(
    .SLOT_W      (SLOT_W),
    .MAX_CALL_REG(MAX_CALL_REG)
  ) uClassify (
    .slot       (inSlot),
    .legacyRules(legacyEff),
    .unknownOp  (unknownOp),
    .badCallReg (badCallReg),
    .isWideLoad (isWideLoad)
  );

  assign slotFault = !skipEff && (unknownOp || badCallReg);
  assign faultKind = unknownOp ? ERR_UNKNOWN : ERR_CALL_REG;
  assign takeFault = slotFault && (strobes.restart || errReg == ERR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      legacyReg <= 1'b0;
      skipNext  <= 1'b0;
      slotIdx   <= '0;
      countReg  <= '0;
      errReg    <= ERR_NONE;
      errIdxReg <= '0;
    end else if (strobes.accept) begin
      legacyReg <= legacyEff;
      skipNext  <= isWideLoad && !skipEff;
      slotIdx   <= idxEff + CNT_W'(1);
      countReg  <= countBase + (skipEff ? CNT_W'(0) : CNT_W'(1));
      if (takeFault) begin
        errReg    <= faultKind;
        errIdxReg <= idxEff;
      end else if (strobes.restart) begin
        errReg    <= ERR_NONE;
        errIdxReg <= '0;
      end
    end
  end

  assign instrCount = countReg;
  assign errCode    = errReg;
  assign errIndex   = errIdxReg;
endmodule

// File: rtl/bytecode_verifier.sv
module bytecode_verifier
  import bytecode_verifier_pkg::*;
#(
  parameter int SLOT_W       = 64,
  parameter int CNT_W        = 32,
  parameter int VER_W        = 8,
  parameter int MIN_NEW_VER  = 2,
  parameter int MAX_CALL_REG = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [SLOT_W-1:0] inSlot,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [VER_W-1:0]  progVersion,
  output logic              doneValid,
  output logic              donePass,
  output logic [CNT_W-1:0]  doneCount,
  output logic [1:0]        errCode,
  output logic [CNT_W-1:0]  errIndex
);
  ctrlStrobes_t strobes;

  verifier_control uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inLast   (inLast),
    .inReady  (inReady),
    .doneValid(doneValid),
    .strobes  (strobes)
  );

  verifier_datapath #(
    .SLOT_W      (SLOT_W),
    .CNT_W       (CNT_W),
    .VER_W       (VER_W),
    .MIN_NEW_VER (MIN_NEW_VER),
    .MAX_CALL_REG(MAX_CALL_REG)
  ) uData (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .inSlot     (inSlot),
    .progVersion(progVersion),
    .instrCount (doneCount),
    .errCode    (errCode),
    .errIndex   (errIndex)
  );

  assign donePass = (errCode == ERR_NONE);
endmodule

// File: rtl/bytecode_verifier_sva.sv
module bytecode_verifier_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             inFirst,
  input logic             inLast,
  input logic             doneValid,
  input logic             donePass,
  input logic [CNT_W-1:0] doneCount,
  input logic [1:0]       errCode,
  input logic [CNT_W-1:0] errIndex
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!doneValid && errCode == 2'd0 && doneCount == '0 && errIndex == '0)); // R1

  AST_READY_DURING_DONE: assert property (@(posedge clk) disable iff (rst)
    (inReady == !doneValid)); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inLast) |=> doneValid); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid); // R10

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !$past(rst)) |-> $past(inValid && inReady && inLast)); // R10

  AST_PASS_MATCHES_ERR: assert property (@(posedge clk) disable iff (rst)
    doneValid |-> (donePass == (errCode == 2'd0))); // R10

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (errCode != 2'd0 && !(inValid && inReady && inFirst)) |=>
      ($stable(errCode) && $stable(errIndex))); // R9

  AST_ERR_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    errCode != 2'd3); // R9
endmodule

bind bytecode_verifier bytecode_verifier_sva #(.CNT_W(CNT_W)) uSva (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .inFirst  (inFirst),
  .inLast   (inLast),
  .doneValid(doneValid),
  .donePass (donePass),
  .doneCount(doneCount),
  .errCode  (errCode),
  .errIndex (errIndex)
);

// File: tb/tb_bytecode_verifier.sv
`timescale 1ns/1ps
module tb_bytecode_verifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inSlot = '0;
  logic        inFirst = 1'b0;
  logic        inLast = 1'b0;
  logic [7:0]  progVersion = 8'd2;
  logic        doneValid;
  logic        donePass;
  logic [31:0] doneCount;
  logic [1:0]  errCode;
  logic [31:0] errIndex;

  int vecs = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bytecode_verifier dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inSlot(inSlot), .inFirst(inFirst), .inLast(inLast),
    .progVersion(progVersion), .doneValid(doneValid), .donePass(donePass),
    .doneCount(doneCount), .errCode(errCode), .errIndex(errIndex)
  );

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [3:0] src,
                                     input logic [31:0] imm);
    return {imm, 16'h0000, src, 4'h0, op};
  endfunction

  function automatic bit inList(input logic [7:0] op, input logic [7:0] lst[]);
    foreach (lst[i]) if (lst[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  // behavioural model of the rules in the requirements
  function automatic int classify(input logic [63:0] s, input bit legacy);
    logic [7:0] dropped[] = '{8'h00, 8'h18, 8'hD4, 8'h61, 8'h62, 8'h63, 8'h69,
                              8'h6A, 8'h6B, 8'h71, 8'h72, 8'h73, 8'h79, 8'h7A, 8'h7B};
    logic [7:0] added[] = '{8'hF7, 8'h27, 8'h2C, 8'h2F, 8'h37, 8'h3C, 8'h3F,
                            8'h87, 8'h8C, 8'h8F, 8'h97, 8'h9C, 8'h9F};
    if (legacy) begin
      if (inList(s[7:0], added)) return 1;
      if (s[7:0] == 8'h8D && s[63:32] > 32'd9) return 2;
    end else begin
      if (inList(s[7:0], dropped)) return 1;
      if (s[7:0] == 8'h8D && s[15:12] > 4'd9) return 2;
    end
    return 0;
  endfunction

  bit mDone, mLegacy, mSkip;
  int mIdx, mCount, mErr, mErrIdx;

  always @(posedge clk) begin
    if (rst) begin
      mDone = 0; mLegacy = 0; mSkip = 0;
      mIdx = 0; mCount = 0; mErr = 0; mErrIdx = 0;
    end else begin
      bit acc;
      acc = inValid && !mDone;
      if (acc) begin
        bit skipNow;
        int k;
        if (inFirst) begin
          mLegacy = (progVersion < 8'd2);
          mIdx = 0; mCount = 0; mErr = 0; mErrIdx = 0; mSkip = 0;
        end
        skipNow = mSkip;
        k = skipNow ? 0 : classify(inSlot, mLegacy);
        if (k != 0 && mErr == 0) begin mErr = k; mErrIdx = mIdx; end
        if (!skipNow) mCount++;
        mSkip = mLegacy && !skipNow && inSlot[7:0] == 8'h18;
        mIdx++;
      end
      mDone = acc && inLast;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R10 doneValid vs model", doneValid, mDone);
      check("R2 inReady vs model", inReady, !mDone);
      check("R9 errCode vs model", errCode, mErr);
      check("R9 errIndex vs model", errIndex, mErrIdx);
      if (mDone) begin
        check("R8 doneCount vs model", doneCount, mCount);
        check("R10 donePass vs model", donePass, mErr == 0);
      end
    end
  end

  logic [63:0] prog[$];

  task automatic runProg(input string tag, input logic [7:0] ver,
                         input int eCode, input int eIdx, input int eCount);
    foreach (prog[i]) begin
      @(negedge clk);
      inValid = 1; inSlot = prog[i]; progVersion = ver;
      inFirst = (i == 0); inLast = (i == prog.size() - 1);
    end
    @(negedge clk);
    inValid = 0; inFirst = 0; inLast = 0;
    check({tag, " done strobe"}, doneValid, 1);
    check({tag, " ready low"}, inReady, 0);
    check({tag, " code"}, errCode, eCode);
    check({tag, " index"}, errIndex, eIdx);
    check({tag, " count"}, doneCount, eCount);
    check({tag, " pass"}, donePass, eCode == 0);
    @(negedge clk);
    check({tag, " R10 strobe drops"}, doneValid, 0);
    prog.delete();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 doneValid reset", doneValid, 0);
        check("R1 errCode reset", errCode, 0);
        check("R1 doneCount reset", doneCount, 0);
        check("R1 inReady reset", inReady, 1);
        prog = '{mk(8'hF7,0,32'h1), mk(8'h27,0,0), mk(8'h9F,0,0), mk(8'h8D,9,0), mk(8'h07,0,0)};
        runProg("R5 R6 new clean", 2, 0, 0, 5);
        prog = '{mk(8'h8D,0,32'hFF), mk(8'h8D,4'hA,0), mk(8'h07,0,0)};
        runProg("R6 call src bad", 3, 2, 1, 3);
        prog = '{mk(8'h07,0,0), mk(8'h07,0,0), mk(8'h18,0,0), mk(8'h00,0,0), mk(8'h61,0,0), mk(8'h07,0,0)};
        runProg("R3 R9 wide load first fault", 2, 1, 2, 6);
        prog = '{mk(8'hD4,0,0)};
        runProg("R3 le conversion", 2, 1, 0, 1);
        prog = '{mk(8'h07,0,0), mk(8'h7B,0,0), mk(8'h8D,4'hF,0)};
        runProg("R4 legacy memory op", 2, 1, 1, 3);
        prog = '{mk(8'h3C,0,0), mk(8'h8C,0,0), mk(8'h37,0,0), mk(8'h2F,0,0)};
        runProg("R5 relocated ops", 2, 0, 0, 4);
        prog = '{mk(8'h18,0,0), mk(8'h00,0,0), mk(8'h61,0,0), mk(8'h8D,4'hF,5)};
        runProg("R7 R8 legacy clean", 1, 0, 0, 3);
        prog = '{mk(8'h07,0,0), mk(8'hF7,0,0), mk(8'h8D,0,32'd10)};
        runProg("R7 legacy new-only op", 0, 1, 1, 3);
        prog = '{mk(8'h8D,0,32'd10)};
        runProg("R7 legacy call imm", 1, 2, 0, 1);
        prog = '{mk(8'h18,0,0), mk(8'hF7,0,0)};
        runProg("R8 second half not decoded", 1, 0, 0, 1);
        prog = '{mk(8'h07,0,0), mk(8'h07,0,0)};
        runProg("R9 cleared on new program", 2, 0, 0, 2);
      end
      begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule